// File: doc/BRIEF.md
# Dual Complex Adder-Accumulator with Output Scaling

This block holds two matched adder/subtractor lanes that work on complex samples. The A port carries the real stream and the B port carries the imaginary stream. Each port has its own input register with an active-low load enable. The real lane combines A with B and the imaginary lane combines B with A. Each lane computes a 20-bit two's-complement result. A feedback select makes both lanes use their own previous result in place of the second operand, so they accumulate. One shared clear resets both accumulations.

All control inputs are registered before they act. A 3-bit shift select picks a 16-bit window from each 20-bit result and loads it into the lane's output register. A single overflow flag reports two cases: a window that cannot hold its result, or a lane whose 20-bit sum wrapped. A delay select gives the real lane a copy of the A register one cycle older than the current one.

Top module: `cplx_addacc`

## Requirements
- R1: While `rst_n` is low, and after its release until new data arrives, `reOut`, `imOut` and `ovf` are 0. All internal registers, including both accumulators, start at 0.
- R2: The A input register loads `aIn` at a rising edge only when `aLoadN` is 0. The B register does the same with `bIn` and `bLoadN`. Otherwise each register keeps its value.
- R3: Every control input (`reOp`, `imOp`, `accClr`, `fbSel`, `scaleSel`, `dlySel`) is captured at a rising edge. It governs the result that the outputs show after the next rising edge. Data captured at the same edge as a control value is combined under that control value.
- R4: The lane operation codes are 00 = P+Q, 01 = P−Q, 10 = Q−P and 11 = P. The real lane uses P = A register and Q = B register. The imaginary lane uses P = B register and Q = A register. Operands are sign-extended to 20 bits.
- R5: When the registered `fbSel` is 1, each lane replaces its Q operand with its own 20-bit accumulator value.
- R6: When the registered `accClr` is 1, both accumulators become 0. In that cycle both outputs show 0 and `ovf` is 0.
- R7: The shift amount is k = min(`scaleSel`, 4). Each output shows bits [15+k:k] of its lane's new 20-bit result.
- R8: `ovf` is 1 exactly when either lane's true result falls outside the 20-bit signed range, or either lane's result bits above position 15+k are not all copies of bit 15+k. When a lane's 20-bit sum overflows, it wraps modulo 2^20.
- R9: When the registered `dlySel` is 1, the real lane's P operand is the value the A register held one cycle before its current value. This delayed copy follows the A register on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| aIn | input | 16 | Real-stream sample, two's complement |
| bIn | input | 16 | Imaginary-stream sample, two's complement |
| aLoadN | input | 1 | Active-low load enable of the A register |
| bLoadN | input | 1 | Active-low load enable of the B register |
| reOp | input | 2 | Real lane operation code |
| imOp | input | 2 | Imaginary lane operation code |
| accClr | input | 1 | Shared accumulator clear |
| fbSel | input | 1 | Feedback select for both lanes |
| scaleSel | input | 3 | Output window select |
| dlySel | input | 1 | Delayed A operand for the real lane |
| reOut | output | 16 | Registered real-lane window |
| imOut | output | 16 | Registered imaginary-lane window |
| ovf | output | 1 | Range or adder overflow flag |

## Verification
The bound properties check the following relations from the port side on every cycle:
- the clear zeroes both outputs and the flag two edges later;
- a pass-through real lane reproduces the A sample;
- a non-feedback imaginary add gives the low 16 bits of B plus A;
- two pass-through lanes with the widest window never raise the flag.

Only the bench's behavioural model can show the following, across scenarios that run long random sequences:
- accumulation over many cycles and the 20-bit wrap;
- each window position together with its range test;
- the delayed operand's history;
- the interaction of held input registers with changing controls.

// File: rtl/cplx_addacc_pkg.sv
`timescale 1ns/1ps
package cplx_addacc_pkg;
  localparam int NUM_LANES = 2;
  localparam int OP_W      = 2;
  localparam int SCALE_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_PASS = 2'b11
  } op_e;

  // lane 0 = real, lane 1 = imaginary
  typedef struct packed {
    op_e [NUM_LANES-1:0] laneOp;
    logic                clr;
    logic                fb;
    logic                dly;
    logic [SCALE_W-1:0]  shift;
  } strobe_t;
endpackage

// File: rtl/cplx_addacc_ctrl.sv
`timescale 1ns/1ps
module cplx_addacc_ctrl
  import cplx_addacc_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OP_W-1:0]    reOp,
  input  logic [OP_W-1:0]    imOp,
  input  logic               accClr,
  input  logic               fbSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               dlySel,
  output strobe_t            strb
);
  localparam logic [SCALE_W-1:0] MAX_SHIFT = SCALE_W'(GUARD_W);

  logic [OP_W-1:0]    reOpQ, imOpQ;
  logic               clrQ, fbQ, dlyQ;
  logic [SCALE_W-1:0] scaleQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reOpQ  <= '0;
      imOpQ  <= '0;
      clrQ   <= 1'b0;
      fbQ    <= 1'b0;
      dlyQ   <= 1'b0;
      scaleQ <= '0;
    end else begin
      reOpQ  <= reOp;
      imOpQ  <= imOp;
      clrQ   <= accClr;
      fbQ    <= fbSel;
      dlyQ   <= dlySel;
      scaleQ <= scaleSel;
    end
  end

  always_comb begin
    strb.laneOp[0] = op_e'(reOpQ);
    strb.laneOp[1] = op_e'(imOpQ);
    strb.clr       = clrQ;
    strb.fb        = fbQ;
    strb.dly       = dlyQ;
    strb.shift     = (scaleQ > MAX_SHIFT) ? MAX_SHIFT : scaleQ;
  end
endmodule

// File: rtl/cplx_addacc_lane.sv
`timescale 1ns/1ps
module cplx_addacc_lane
  import cplx_addacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  pOpnd,
  input  logic [DATA_W-1:0]  qOpnd,
  input  op_e                op,
  input  logic               fb,
  input  logic               clr,
  input  logic [SCALE_W-1:0] shift,
  output logic [DATA_W-1:0]  dataOut,
  output logic               ovfOut
);
  localparam int SUM_W = DATA_W + GUARD_W;
  localparam int EXT_W = SUM_W + 1;

  logic [SUM_W-1:0]        acc, pExt, qExt, qSel, nextAcc;
  logic [EXT_W-1:0]        pW, qW, rawW;
  logic signed [SUM_W-1:0] shifted;
  logic                    addOvf, fieldOvf;

  always_comb begin
    pExt = {{GUARD_W{pOpnd[DATA_W-1]}}, pOpnd};
    qExt = {{GUARD_W{qOpnd[DATA_W-1]}}, qOpnd};
    qSel = fb ? acc : qExt;
    pW   = {pExt[SUM_W-1], pExt};
    qW   = {qSel[SUM_W-1], qSel};
    case (op)
      OP_ADD:  rawW = pW + qW;
      OP_SUB:  rawW = pW - qW;
      OP_RSUB: rawW = qW - pW;
      default: rawW = pW;
    endcase
    if (clr) rawW = '0;
    nextAcc  = rawW[SUM_W-1:0];
    addOvf   = rawW[EXT_W-1] ^ rawW[SUM_W-1];
    shifted  = $signed(nextAcc) >>> shift;
    fieldOvf = (shifted != {{GUARD_W{shifted[DATA_W-1]}}, shifted[DATA_W-1:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      dataOut <= '0;
      ovfOut  <= 1'b0;
    end else begin
      acc     <= nextAcc;
      dataOut <= shifted[DATA_W-1:0];
      ovfOut  <= addOvf | fieldOvf;
    end
  end
endmodule

// File: rtl/cplx_addacc_dp.sv
`timescale 1ns/1ps
module cplx_addacc_dp
  import cplx_addacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              aLoadN,
  input  logic              bLoadN,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] reOut,
  output logic [DATA_W-1:0] imOut,
  output logic              ovf
);
  logic [DATA_W-1:0]    aReg, bReg, aDly;
  logic [DATA_W-1:0]    pOp     [NUM_LANES];
  logic [DATA_W-1:0]    qOp     [NUM_LANES];
  logic [DATA_W-1:0]    laneOut [NUM_LANES];
  logic [NUM_LANES-1:0] laneOvf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg <= '0;
      bReg <= '0;
      aDly <= '0;
    end else begin
      if (!aLoadN) aReg <= aIn;
      if (!bLoadN) bReg <= bIn;
      aDly <= aReg;
    end
  end

  always_comb begin
    pOp[0] = strb.dly ? aDly : aReg;
    qOp[0] = bReg;
    pOp[1] = bReg;
    qOp[1] = aReg;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    cplx_addacc_lane #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pOpnd  (pOp[i]),
      .qOpnd  (qOp[i]),
      .op     (strb.laneOp[i]),
      .fb     (strb.fb),
      .clr    (strb.clr),
      .shift  (strb.shift),
      .dataOut(laneOut[i]),
      .ovfOut (laneOvf[i])
    );
  end

  assign reOut = laneOut[0];
  assign imOut = laneOut[1];
  assign ovf   = |laneOvf;
endmodule

// File: rtl/cplx_addacc.sv
`timescale 1ns/1ps
module cplx_addacc
  import cplx_addacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  aIn,
  input  logic [DATA_W-1:0]  bIn,
  input  logic               aLoadN,
  input  logic               bLoadN,
  input  logic [OP_W-1:0]    reOp,
  input  logic [OP_W-1:0]    imOp,
  input  logic               accClr,
  input  logic               fbSel,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               dlySel,
  output logic [DATA_W-1:0]  reOut,
  output logic [DATA_W-1:0]  imOut,
  output logic               ovf
);
  strobe_t strb;

  cplx_addacc_ctrl #(.GUARD_W(GUARD_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reOp(reOp), .imOp(imOp), .accClr(accClr),
    .fbSel(fbSel), .scaleSel(scaleSel), .dlySel(dlySel), .strb(strb)
  );

  cplx_addacc_dp #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .aIn(aIn), .bIn(bIn), .aLoadN(aLoadN),
    .bLoadN(bLoadN), .strb(strb), .reOut(reOut), .imOut(imOut), .ovf(ovf)
  );
endmodule

// File: rtl/cplx_addacc_chk.sv
`timescale 1ns/1ps
module cplx_addacc_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic              aLoadN,
  input logic              bLoadN,
  input logic [1:0]        reOp,
  input logic [1:0]        imOp,
  input logic              accClr,
  input logic              fbSel,
  input logic [2:0]        scaleSel,
  input logic              dlySel,
  input logic [DATA_W-1:0] reOut,
  input logic [DATA_W-1:0] imOut,
  input logic              ovf
);
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accClr |=> ##1 (reOut == '0 && imOut == '0 && !ovf));

  p_pass_real_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reOp == 2'b11 && !accClr && !dlySel && scaleSel == 3'd0 && !aLoadN)
      |=> ##1 (reOut == $past(aIn, 2)));

  p_add_imag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (imOp == 2'b00 && !fbSel && !accClr && scaleSel == 3'd0 && !aLoadN && !bLoadN)
      |=> ##1 (imOut == DATA_W'($past(bIn, 2) + $past(aIn, 2))));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reOp == 2'b11 && imOp == 2'b11 && !fbSel && scaleSel >= 3'd4) |=> ##1 !ovf);
endmodule

bind cplx_addacc cplx_addacc_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cplx_addacc_tb_top.sv
`timescale 1ns/1ps
module cplx_addacc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] aIn = '0, bIn = '0;
  logic        aLoadN = 1'b0, bLoadN = 1'b0;
  logic [1:0]  reOp = '0, imOp = '0;
  logic        accClr = 1'b0, fbSel = 1'b0, dlySel = 1'b0;
  logic [2:0]  scaleSel = '0;
  logic [15:0] reOut, imOut;
  logic        ovf;

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    running = 1'b1;

  // reference model state
  int aR, bR, aD, opR, opI, sc, accR, accI, eRe, eIm;
  bit clrM, fbM, dlyM, eOv;

  always #2.5 clk = ~clk;

  cplx_addacc dut_i (.*);

  function automatic int w20(int v);
    logic [19:0] t = v[19:0];
    return int'($signed(t));
  endfunction

  function automatic int w16(int v);
    logic [15:0] t = v[15:0];
    return int'($signed(t));
  endfunction

  function automatic int laneOp(int op, int p, int q);
    case (op)
      0: return p + q;
      1: return p - q;
      2: return q - p;
      default: return p;
    endcase
  endfunction

  task automatic laneStep(int op, int p, int q, ref int acc, output int fld, output bit ov);
    int raw, nw, k, sh;
    raw = clrM ? 0 : laneOp(op, p, q);
    nw  = w20(raw);
    k   = (sc > 4) ? 4 : sc;
    sh  = nw >>> k;
    fld = w16(sh);
    ov  = (raw != nw) || (sh != fld);
    acc = nw;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aR = 0; bR = 0; aD = 0; opR = 0; opI = 0; sc = 0; accR = 0; accI = 0;
      clrM = 0; fbM = 0; dlyM = 0; eRe = 0; eIm = 0; eOv = 0;
    end else begin
      int fr, fi, pr, qr, qi, ar0, br0;
      bit ovr, ovi;
      ar0 = aR; br0 = bR;
      pr = dlyM ? aD : ar0;
      qr = fbM ? accR : br0;
      qi = fbM ? accI : ar0;
      laneStep(opR, pr, qr, accR, fr, ovr);
      laneStep(opI, br0, qi, accI, fi, ovi);
      eRe = fr; eIm = fi; eOv = ovr | ovi;
      aD = ar0;
      if (!aLoadN) aR = int'($signed(aIn));
      if (!bLoadN) bR = int'($signed(bIn));
      opR = reOp; opI = imOp; clrM = accClr; fbM = fbSel; dlyM = dlySel; sc = scaleSel;
    end
  end

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("reOut", int'(reOut), eRe & 32'hFFFF);
      chk("imOut", int'(imOut), eIm & 32'hFFFF);
      chk("ovf", int'(ovf), int'(eOv));
    end
  end

  task automatic phase(string t, int n, int mode);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      aIn = 16'($urandom); bIn = 16'($urandom);
      aLoadN = 0; bLoadN = 0; accClr = 0; fbSel = 0; dlySel = 0; scaleSel = 0;
      reOp = 2'($urandom); imOp = 2'($urandom);
      case (mode)
        2: begin aLoadN = 1'($urandom); bLoadN = 1'($urandom); end
        5: begin fbSel = 1; accClr = (i == 0); reOp = 2'($urandom_range(0, 1)); imOp = reOp;
                 aIn = 16'($urandom_range(0, 4000)); bIn = 16'($urandom_range(0, 4000)); end
        6: begin fbSel = 1; accClr = ($urandom_range(0, 3) == 0); end
        7: begin fbSel = 1; reOp = 0; imOp = 1; scaleSel = 3'($urandom); end
        8: begin fbSel = 1; reOp = 0; imOp = 2; aIn = 16'h7FF0; bIn = 16'h8005;
                 scaleSel = 3'($urandom_range(0, 4)); accClr = (i == 0); end
        9: begin dlySel = 1'($urandom); aLoadN = 1'($urandom); end
        3: begin aLoadN = 1'($urandom); bLoadN = 1'($urandom); accClr = ($urandom_range(0, 7) == 0);
                 fbSel = 1'($urandom); dlySel = 1'($urandom); scaleSel = 3'($urandom); end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("reOut R1", int'(reOut), 0);
    chk("imOut R1", int'(imOut), 0);
    chk("ovf R1", int'(ovf), 0);
    rst_n = 1'b1;
    phase("R4", 60, 4);
    phase("R2", 60, 2);
    phase("R5", 80, 5);
    phase("R6", 80, 6);
    phase("R7", 120, 7);
    phase("R8", 80, 8);
    phase("R9", 80, 9);
    phase("R3", 400, 3);
    @(negedge clk);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    running = 1'b0;
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule